// File: doc/BRIEF.md
# Peripheral Event Transfer Channel Engine

This block moves exactly one data item per service request, on behalf of one of eight channels. When a channel's request line pulses, the engine records it as pending. When the engine is idle, it takes the lowest-numbered pending channel. It reads that channel's destination and source pointers from an internal pointer store, then performs one read on a synchronous memory port followed by one write. Each channel has a width select input: a 1 chooses a byte and a 0 chooses a 16-bit word. In word mode, an odd source or destination pointer stops the move before any memory access, and a one-cycle illegal-access trap is raised in place of the completion strobe.

The pointer store is a window of sixteen 16-bit locations at byte addresses 0xFCE0 to 0xFCFE. A host port reads and writes this window like ordinary RAM, so slots belonging to idle channels can hold any data. The slots are arranged per channel: the destination pointer of channel n is at 0xFCE0 + 4n and the source pointer at 0xFCE2 + 4n. A host write that lands in the single cycle in which the engine loads a channel's pointers is dropped, so a pointer is never loaded while it is half updated.

Top module: `pec_xfer_engine`

## Requirements
- R1: After a cycle with rst_n low, done, trap and mem_req are 0, host_rdata is 0 and every pointer slot reads as 0.
- R2: A host access with host_sel=1 addresses the 16-bit slot at byte address (host_addr with bit 0 ignored). The destination slot of channel n is at 0xFCE0+4n and the source slot at 0xFCE2+4n. A read (host_we=0) updates host_rdata at the next edge and returns 0 outside 0xFCE0..0xFCFF. A write outside that range changes nothing. host_rdata holds its value between reads.
- R3: With chan_byte[n]=1, the transfer reads the source with mem_byte=1 and then writes the destination with mem_byte=1. mem_wdata is mem_rdata[7:0] zero-extended to 16 bits.
- R4: With chan_byte[n]=0, the transfer reads and writes 16 bits with mem_byte=0. mem_wdata equals the mem_rdata returned for the source address.
- R5: In word mode, if either pointer is odd, no memory access is made, trap is 1 for exactly one cycle and done stays 0.
- R6: In byte mode, odd pointers are legal and the transfer completes normally.
- R7: Take the edge that samples a request to an idle engine with nothing pending as edge 0, and call the cycle after edge k cycle k. The read access (mem_req=1, mem_we=0, mem_addr=source) occupies cycle 2. The write access (mem_req=1, mem_we=1, mem_addr=destination) occupies cycle 3. done is 1 in cycle 4, or trap is 1 in cycle 2.
- R8: Requests that arrive while a transfer runs stay pending and are served after the engine returns to idle. Among pending channels, the lowest number is served first, and each takes the full sequence.
- R9: A host write sampled in the pointer-load cycle (cycle 1 of R7) is dropped. A host write sampled in any other cycle takes effect.
- R10: done and trap are never 1 together, each lasts one cycle, and xfer_chan shows the served channel number while either is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 8 | One service request line per channel, sampled each edge |
| chan_byte | input | 8 | Per-channel width select: 1 byte, 0 word |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_byte | output | 1 | Access is one byte |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read access |
| done | output | 1 | Transfer complete strobe |
| trap | output | 1 | Illegal word access strobe |
| xfer_chan | output | 3 | Channel being served |

## Verification
The read access is due two cycles after the edge that samples a request, the write three cycles after, and done four cycles after. A trap is due two cycles after, and host read data one cycle after its strobe. The bench keeps its own per-cycle model of phase, pending set, pointer store and byte memory. It advances the model at each rising edge and compares every output at the following falling edge, so each result is checked in the exact cycle it is due. Directed sequences add the explicit cycle counts for done and trap, the order in which two pending channels are served, and host writes placed in the pointer-load cycle and in the cycle after it.

// File: rtl/pec_pkg.sv
// Package: shared types and constants for the event transfer engine.
// Assumes: byte lane is the low 8 bits of a data word.
package pec_pkg;

    localparam int BYTE_W = 8;

    // Engine sequencer phases, in the order a transfer walks them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } pec_state_e;

endpackage

// File: rtl/pec_ptr_ram.sv
// Module: pointer store. Holds 2*NUM_CHAN 16-bit slots in a byte-addressed
// window at BASE. Host port gives registered reads and writes; the engine
// gets an asynchronous read of one channel's destination/source pair.
// Assumes: BASE is aligned to the window size; wr_lock drops host writes.
module pec_ptr_ram #(
    parameter int              NUM_CHAN = 8,
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 16,
    parameter logic [15:0]     BASE     = 16'hFCE0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_sel,
    input  logic                          host_we,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    input  logic                          wr_lock,
    input  logic [$clog2(NUM_CHAN)-1:0]   rd_chan,
    output logic [DATA_W-1:0]             rd_dst,
    output logic [DATA_W-1:0]             rd_src
);
    localparam int NUM_PTR = 2 * NUM_CHAN;
    localparam int IDX_W   = $clog2(NUM_PTR);
    localparam int WIN_LSB = IDX_W + 1;

    logic [DATA_W-1:0] slot_q [NUM_PTR];
    logic              win_hit;
    logic [IDX_W-1:0]  host_idx;
    logic [IDX_W-1:0]  dst_idx;
    logic [IDX_W-1:0]  src_idx;

    // Decode whether the host address falls in the window and which slot.
    always_comb begin
        win_hit  = (host_addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
        host_idx = host_addr[WIN_LSB-1:1];
        dst_idx  = {rd_chan, 1'b0};
        src_idx  = {rd_chan, 1'b1};
    end

    // Slot storage: reset clear, host write unless the engine is loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PTR; i++) slot_q[i] <= '0;
        end else if (host_sel && host_we && win_hit && !wr_lock) begin
            slot_q[host_idx] <= host_wdata;
        end
    end

    // Host read register: updated only on a read strobe, zero outside window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_sel && !host_we) begin
            host_rdata <= win_hit ? slot_q[host_idx] : '0;
        end
    end

    // Engine-side pointer pair for the selected channel.
    always_comb begin
        rd_dst = slot_q[dst_idx];
        rd_src = slot_q[src_idx];
    end

endmodule

// File: rtl/pec_req_pend.sv
// Module: pending-request set. Collects request pulses per channel and
// offers the lowest-numbered pending channel to the sequencer.
// Assumes: take is asserted only when any is high; pick is then valid.
module pec_req_pend #(
    parameter int NUM_CHAN = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CHAN-1:0]           req,
    input  logic                          take,
    output logic                          any,
    output logic [$clog2(NUM_CHAN)-1:0]   pick
);
    localparam int CHAN_W = $clog2(NUM_CHAN);

    logic [NUM_CHAN-1:0] pend_q;
    logic [NUM_CHAN-1:0] take_mask;

    // Lowest set bit wins: scan downward so the last hit is the smallest.
    always_comb begin
        pick = '0;
        for (int i = NUM_CHAN - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = CHAN_W'(i);
        end
        any       = |pend_q;
        take_mask = take ? (NUM_CHAN'(1) << pick) : '0;
    end

    // Pending register: clear the granted bit, merge new pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~take_mask) | req;
    end

endmodule

// File: rtl/pec_seq.sv
// Module: transfer sequencer. Walks IDLE, FETCH, READ, WRITE, DONE (or
// FAULT on a misaligned word) and drives the memory port.
// Assumes: memory answers a read with data on mem_rdata the next cycle
// and never stalls.
module pec_seq #(
    parameter int NUM_CHAN = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          any,
    input  logic [$clog2(NUM_CHAN)-1:0]   pick,
    output logic                          take,
    input  logic [NUM_CHAN-1:0]           chan_byte,
    output logic [$clog2(NUM_CHAN)-1:0]   ptr_chan,
    input  logic [DATA_W-1:0]             rd_dst,
    input  logic [DATA_W-1:0]             rd_src,
    output logic                          fetching,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic                          mem_byte,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          done,
    output logic                          trap,
    output logic [$clog2(NUM_CHAN)-1:0]   xfer_chan
);
    import pec_pkg::*;

    localparam int CHAN_W = $clog2(NUM_CHAN);

    pec_state_e          state_q, state_d;
    logic [CHAN_W-1:0]   chan_q;
    logic [ADDR_W-1:0]   src_q, dst_q;
    logic                byte_q;
    logic                misalign;

    // Alignment test on the pointers being loaded this cycle.
    always_comb begin
        misalign = !chan_byte[chan_q] && (rd_src[0] || rd_dst[0]);
    end

    // Next-state logic and grant to the pending set.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        case (state_q)
            ST_IDLE:  if (any) begin
                          state_d = ST_FETCH;
                          take    = 1'b1;
                      end
            ST_FETCH: state_d = misalign ? ST_FAULT : ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Channel latch on grant, pointer and width latch on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            byte_q <= 1'b0;
        end else begin
            if (take) chan_q <= pick;
            if (state_q == ST_FETCH) begin
                src_q  <= rd_src[ADDR_W-1:0];
                dst_q  <= rd_dst[ADDR_W-1:0];
                byte_q <= chan_byte[chan_q];
            end
        end
    end

    // Memory port, strobes and lock, decoded from the phase.
    always_comb begin
        ptr_chan  = chan_q;
        fetching  = (state_q == ST_FETCH);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_byte  = byte_q;
        mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
        mem_wdata = byte_q ? {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]}
                           : mem_rdata;
        done      = (state_q == ST_DONE);
        trap      = (state_q == ST_FAULT);
        xfer_chan = chan_q;
    end

endmodule

// File: rtl/pec_xfer_engine.sv
// Module: top of the event transfer engine. Connects the pending set,
// the sequencer and the pointer store.
// Assumes: one memory agent with one-cycle read latency and no wait states.
module pec_xfer_engine #(
    parameter int          NUM_CHAN = 8,
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 16,
    parameter logic [15:0] PTR_BASE = 16'hFCE0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CHAN-1:0]           req,
    input  logic [NUM_CHAN-1:0]           chan_byte,
    input  logic                          host_sel,
    input  logic                          host_we,
    input  logic [ADDR_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic                          mem_byte,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          done,
    output logic                          trap,
    output logic [$clog2(NUM_CHAN)-1:0]   xfer_chan
);
    localparam int CHAN_W = $clog2(NUM_CHAN);

    logic              any, take, fetching;
    logic [CHAN_W-1:0] pick, ptr_chan;
    logic [DATA_W-1:0] rd_dst, rd_src;

    pec_req_pend #(.NUM_CHAN(NUM_CHAN)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .take  (take),
        .any   (any),
        .pick  (pick)
    );

    pec_seq #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .pick      (pick),
        .take      (take),
        .chan_byte (chan_byte),
        .ptr_chan  (ptr_chan),
        .rd_dst    (rd_dst),
        .rd_src    (rd_src),
        .fetching  (fetching),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .trap      (trap),
        .xfer_chan (xfer_chan)
    );

    pec_ptr_ram #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .BASE(PTR_BASE)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .wr_lock    (fetching),
        .rd_chan    (ptr_chan),
        .rd_dst     (rd_dst),
        .rd_src     (rd_src)
    );

endmodule

// File: rtl/pec_xfer_engine_chk.sv
// Module: protocol checker for the transfer engine, bound to the top.
// Assumes: observes ports only.
module pec_xfer_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              trap,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && trap));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_byte) |-> !mem_addr[0]);

    assert_trap_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!mem_req && !$past(mem_req)));

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we));

    assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

endmodule

bind pec_xfer_engine pec_xfer_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .trap     (trap),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_byte (mem_byte),
    .mem_addr (mem_addr)
);

// File: tb/pec_xfer_engine_test.sv
module pec_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic [7:0]  chan_byte = 8'b0001_0110;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [15:0] host_rdata, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, mem_we, mem_byte, done, trap;
    logic [2:0]  xfer_chan;

    always #4 clk = ~clk;

    pec_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .req(req), .chan_byte(chan_byte),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .trap(trap), .xfer_chan(xfer_chan)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit armed = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Byte memory model answering the engine's memory port.
    logic [7:0] bmem [int];
    function automatic logic [7:0] rb(int a);
        return bmem.exists(a) ? bmem[a] : 8'h00;
    endfunction

    logic        c_req, c_we, c_byte;
    logic [15:0] c_addr, c_wdata;
    always @(negedge clk) begin
        c_req = mem_req; c_we = mem_we; c_byte = mem_byte;
        c_addr = mem_addr; c_wdata = mem_wdata;
    end
    always @(posedge clk) begin
        if (c_req && !c_we)
            mem_rdata <= c_byte ? {8'h00, rb(int'(c_addr))}
                                : {rb(int'(c_addr) + 1), rb(int'(c_addr))};
        if (c_req && c_we) begin
            bmem[int'(c_addr)] = c_wdata[7:0];
            if (!c_byte) bmem[int'(c_addr) + 1] = c_wdata[15:8];
        end
    end

    // Behavioural reference: phase 0 idle,1 load,2 read,3 write,4 done,5 trap.
    int          m_phase = 0, m_ch = 0, ph0;
    logic [7:0]  m_pend = '0;
    logic [15:0] m_ptr [16];
    logic [15:0] m_src = '0, m_dst = '0, m_rdata = '0;
    logic        m_byte = 1'b0;
    int          hidx;
    bit          hhit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pend = '0; m_rdata = '0;
            for (int i = 0; i < 16; i++) m_ptr[i] = '0;
        end else begin
            ph0  = m_phase;
            hhit = (host_addr >= 16'hFCE0) && (host_addr <= 16'hFCFF);
            hidx = (int'(host_addr) - 'hFCE0) / 2;
            case (ph0)
                0: if (m_pend != 0) begin
                       for (int i = 7; i >= 0; i--) if (m_pend[i]) m_ch = i;
                       m_pend[m_ch] = 1'b0;
                       m_phase = 1;
                   end
                1: begin
                       m_dst  = m_ptr[2*m_ch];
                       m_src  = m_ptr[2*m_ch+1];
                       m_byte = chan_byte[m_ch];
                       m_phase = (!m_byte && (m_src[0] || m_dst[0])) ? 5 : 2;
                   end
                2: m_phase = 3;
                3: m_phase = 4;
                default: m_phase = 0;
            endcase
            m_pend = m_pend | req;
            if (host_sel && !host_we) m_rdata = hhit ? m_ptr[hidx] : 16'h0;
            if (host_sel && host_we && hhit && ph0 != 1) m_ptr[hidx] = host_wdata;
        end
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (armed && rst_n) begin
            chk("R10 done", done, m_phase == 4);
            chk("R5 trap", trap, m_phase == 5);
            chk("R7 mem_req", mem_req, m_phase == 2 || m_phase == 3);
            chk("R2 host_rdata", host_rdata, m_rdata);
            if (m_phase == 2 || m_phase == 3) begin
                chk("R7 mem_we", mem_we, m_phase == 3);
                chk("R7 mem_addr", mem_addr, m_phase == 2 ? m_src : m_dst);
                chk(m_byte ? "R3 mem_byte" : "R4 mem_byte", mem_byte, m_byte);
            end
            if (m_phase == 3)
                chk(m_byte ? "R3 wdata" : "R4 wdata", mem_wdata,
                    m_byte ? {8'h00, rb(int'(m_src))}
                           : {rb(int'(m_src) + 1), rb(int'(m_src))});
            if (m_phase == 4 || m_phase == 5) chk("R10 xfer_chan", xfer_chan, m_ch);
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp<20000", cyc);
            summary();
        end
    end

    task automatic host_wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk); host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_sel = 0; host_we = 0;
    endtask

    task automatic host_rd(logic [15:0] a, output logic [15:0] d);
        @(negedge clk); host_sel = 1; host_we = 0; host_addr = a;
        @(negedge clk); host_sel = 0; d = host_rdata;
    endtask

    // Pulse req, return the cycle number (R7 numbering) of done or trap.
    task automatic fire(logic [7:0] m, output int n);
        @(negedge clk); req = m;
        @(negedge clk); req = '0; n = 0;
        while (!(done || trap) && n < 50) begin @(negedge clk); n++; end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    logic [15:0] rd;
    int n;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; armed = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0); chk("R1 trap", trap, 0);
        chk("R1 mem_req", mem_req, 0); chk("R1 host_rdata", host_rdata, 0);
        host_rd(16'hFCEA, rd); chk("R1 slot", rd, 0);

        // R2: map, readback, out-of-window ignored
        for (int i = 0; i < 16; i++) host_wr(16'hFCE0 + 16'(2*i), 16'hA000 + 16'(i));
        host_wr(16'hFD00, 16'h1234); host_wr(16'hFCDE, 16'h5678);
        for (int i = 0; i < 16; i++) begin
            host_rd(16'hFCE0 + 16'(2*i), rd); chk("R2 slot", rd, 16'hA000 + 16'(i));
        end
        host_rd(16'hFD00, rd); chk("R2 outside", rd, 0);
        @(negedge clk); chk("R2 hold", host_rdata, 0);

        // Channel setup: dst at FCE0+4n, src at FCE2+4n
        host_wr(16'hFCE8, 16'h2003); host_wr(16'hFCEA, 16'h1001); // ch2 byte
        host_wr(16'hFCF4, 16'h4000); host_wr(16'hFCF6, 16'h3000); // ch5 word
        host_wr(16'hFCF8, 16'h4000); host_wr(16'hFCFA, 16'h3001); // ch6 odd src
        host_wr(16'hFCFC, 16'h4005); host_wr(16'hFCFE, 16'h3000); // ch7 odd dst
        host_wr(16'hFCE4, 16'h2001); host_wr(16'hFCE6, 16'h1003); // ch1 byte
        host_wr(16'hFCEC, 16'h4010); host_wr(16'hFCEE, 16'h3010); // ch3 word
        host_wr(16'hFCE0, 16'h4020); host_wr(16'hFCE2, 16'h3020); // ch0 word
        host_wr(16'hFCF0, 16'h5000); host_wr(16'hFCF2, 16'h1003); // ch4 byte
        bmem[16'h1001] = 8'hA5; bmem[16'h1003] = 8'h3C; bmem[16'h2004] = 8'h77;
        bmem[16'h3000] = 8'hEF; bmem[16'h3001] = 8'hBE;
        bmem[16'h3010] = 8'h11; bmem[16'h3011] = 8'h22;
        bmem[16'h3020] = 8'h33; bmem[16'h3021] = 8'h44;

        // R3/R6/R7: byte transfer with odd pointers
        fire(8'h04, n); chk("R7 done cycle", n, 4); chk("R6 done", done, 1);
        settle(); chk("R3 byte dst", rb('h2003), 8'hA5); chk("R3 neighbour", rb('h2004), 8'h77);

        // R4: word transfer
        fire(8'h20, n); chk("R7 word done cycle", n, 4);
        settle(); chk("R4 word lo", rb('h4000), 8'hEF); chk("R4 word hi", rb('h4001), 8'hBE);

        // R5: odd source, then odd destination
        bmem[16'h4000] = 8'h00;
        fire(8'h40, n); chk("R5 trap cycle", n, 2); chk("R5 trap", trap, 1);
        settle(); chk("R5 no write", rb('h4000), 8'h00);
        fire(8'h80, n); chk("R5 trap cycle dst", n, 2); chk("R5 done low", done, 0);
        settle(); chk("R5 no write dst", rb('h4005), 8'h00);

        // R8: two at once, lowest first, plus one arriving mid-transfer
        @(negedge clk); req = 8'h0A;
        @(negedge clk); req = 8'h01;
        @(negedge clk); req = 8'h00;
        while (!done) @(negedge clk);
        chk("R8 first", xfer_chan, 1);
        @(negedge clk); while (!done) @(negedge clk);
        chk("R8 second", xfer_chan, 0);
        @(negedge clk); while (!done) @(negedge clk);
        chk("R8 third", xfer_chan, 3);
        settle(); chk("R8 ch3 data", {rb('h4011), rb('h4010)}, 16'h2211);
        chk("R8 ch0 data", {rb('h4021), rb('h4020)}, 16'h4433);

        // R9: write in load cycle dropped, write in read cycle taken
        @(negedge clk); req = 8'h10;
        @(negedge clk); req = 8'h00;                       // cycle 0
        @(negedge clk); host_sel = 1; host_we = 1;         // cycle 1 (load)
        host_addr = 16'hFCF0; host_wdata = 16'h6000;
        @(negedge clk); host_addr = 16'hFCF2; host_wdata = 16'h1001; // cycle 2
        @(negedge clk); host_sel = 0; host_we = 0;
        settle();
        chk("R9 blocked dst", rb('h5000), 8'h3C);
        host_rd(16'hFCF0, rd); chk("R9 blocked slot", rd, 16'h5000);
        host_rd(16'hFCF2, rd); chk("R9 accepted slot", rd, 16'h1001);

        settle();
        summary();
    end
endmodule